// File: doc/BRIEF.md
# Two-Region Resizable Set-Associative Cache

This block is a four-way set-associative lookup of tags and line data. The four ways of each set are divided into a fast region and a slow region. A configuration input sets how many ways belong to the fast region, from one to four. Membership is decided by recency position: the positions nearest the most-recently-used end form the fast region, and the remaining positions form the slow region.

A request first searches the fast region. The slow region is searched only in the following cycle, and only when the fast search found nothing. A slow-region hit is promoted into the fast region: the hit line becomes most-recently-used, and the least-recent fast line drops into the position the hit line left. If both searches fail, the block raises a line request to the next level and waits for a valid/data reply. The new line goes in as most-recently-used, the least-recent fast line moves to the last recency position, and the line that held the last position is evicted.

Each access produces one response. The response gives an outcome code, the recency position at which the hit was found, and the line data. An external controller can use these to decide the best split for the running program.

Top module: `split_way_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` and `fill_req` are 0, and every line is invalid, so the first access to any set misses.
- R2: When the fast region hits, `resp_valid` is high in the cycle right after acceptance. In that response, `resp_kind` is 1, `resp_pos` gives the recency position (0 = most recent, 3 = least recent), and `resp_data` gives the stored line. No line request is made.
- R3: The slow region is searched only after a fast miss. A slow hit responds two cycles after acceptance with `resp_kind` 2 and the recency position it was found at.
- R4: A slow hit at position p moves that line to position 0. Fast positions 0 to k-2 each move down by one, where k is the fast way count. The line that was at fast position k-1 moves to position p.
- R5: When k < 4 and both regions miss, `fill_req` rises two cycles after acceptance, with `fill_addr` equal to the request address. It stays high and stable until `fill_valid`. One cycle after `fill_valid`, the response arrives with `resp_kind` 3, `resp_pos` 0 and `resp_data` equal to the returned data.
- R6: When k = 4 (`cfg_a_ways` = 3), a fast miss skips the slow search, and `fill_req` rises one cycle after acceptance.
- R7: A refilled line takes position 0, and fast positions 0 to k-2 move down by one. The line that was at position k-1 moves to position 3. The line that was at position 3 is evicted, so a later access to it misses.
- R8: A fast hit at position p moves that line to position 0. Positions below p each move down by one, and positions above p do not change.
- R9: `req_ready` is low from acceptance until the response cycle. A request presented while it is low is ignored and does not change `fill_addr`.
- R10: `cfg_a_ways` (value v gives v+1 fast ways) is sampled only while idle. Changing it keeps all contents; it only redraws the boundary between fast and slow recency positions.
- R11: `fill_valid` is ignored when no line request is pending. It produces no response and writes no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_a_ways | input | 2 | Fast-region way count minus one |
| req_valid | input | 1 | Request present |
| req_addr | input | TAG_W+log2(SETS) | Line address; set index in the low bits |
| req_ready | output | 1 | Block idle; a request is accepted this cycle |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_kind | output | 2 | 1 fast hit, 2 slow hit, 3 miss |
| resp_pos | output | 2 | Recency position of the hit, 0 on a miss |
| resp_data | output | DATA_W | Line data |
| fill_req | output | 1 | Line request to the next level |
| fill_addr | output | TAG_W+log2(SETS) | Address of the requested line |
| fill_valid | input | 1 | Next-level reply strobe |
| fill_data | input | DATA_W | Next-level reply data |

## Verification
Some properties are checked by assertions on every cycle:
- the response latency of each outcome kind;
- that a line request is held stable until it is answered;
- that a miss response follows a reply handshake;
- that the block never requests a line while idle;
- that a request made with four fast ways always leads next cycle to either a response or a line request.

The bench scenarios cover what depends on stored state:
- the recency permutations after fast hits, slow hits and refills;
- eviction of the last position;
- the new boundary seen after a split change with no flush;
- that stray requests and stray replies leave no trace.

// File: rtl/swc_pkg.sv
package swc_pkg;
    localparam int WAYS  = 4;
    localparam int POS_W = 2;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_A_HIT = 2'd1,
        KIND_B_HIT = 2'd2,
        KIND_MISS  = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PROBE_B = 2'd1,
        ST_FILL    = 2'd2
    } fsm_e;
endpackage

// File: rtl/swc_probe.sv
// Searches recency positions lo_pos..hi_pos (inclusive) of one set for a tag.
module swc_probe
    import swc_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0]            way_valid,
    input  logic [WAYS-1:0][POS_W-1:0] order,
    input  logic [TAG_W-1:0]           tag,
    input  logic [2:0]                 lo_pos,
    input  logic [2:0]                 hi_pos,
    output logic                       hit,
    output logic [POS_W-1:0]           pos,
    output logic [POS_W-1:0]           way
);
    always_comb begin
        logic found;
        found = 1'b0;
        pos   = '0;
        way   = '0;
        for (int p = 0; p < WAYS; p++) begin
            if (!found && (3'(p) >= lo_pos) && (3'(p) <= hi_pos) &&
                way_valid[order[p]] && (way_tag[order[p]] == tag)) begin
                found = 1'b1;
                pos   = POS_W'(p);
                way   = order[p];
            end
        end
        hit = found;
    end
endmodule

// File: rtl/swc_promote.sv
// Recency permutation that brings position pos to the front, given a_cnt fast ways.
// Inside the fast region: plain move-to-front. Outside: the last fast
// position is exchanged into the vacated slot.
module swc_promote
    import swc_pkg::*;
(
    input  logic [WAYS-1:0][POS_W-1:0] order_in,
    input  logic [POS_W-1:0]           pos,
    input  logic [2:0]                 a_cnt,
    output logic [WAYS-1:0][POS_W-1:0] order_out
);
    logic [POS_W-1:0] a_last;
    logic             in_fast;

    assign a_last  = POS_W'(a_cnt - 3'd1);
    assign in_fast = ({1'b0, pos} < a_cnt);

    always_comb begin
        for (int q = 0; q < WAYS; q++) begin
            if (q == 0) begin
                order_out[q] = order_in[pos];
            end else if (in_fast) begin
                if (POS_W'(q) <= pos) order_out[q] = order_in[(q + WAYS - 1) % WAYS];
                else                  order_out[q] = order_in[q];
            end else begin
                if (3'(q) < a_cnt)         order_out[q] = order_in[(q + WAYS - 1) % WAYS];
                else if (POS_W'(q) == pos) order_out[q] = order_in[a_last];
                else                       order_out[q] = order_in[q];
            end
        end
    end
endmodule

// File: rtl/split_way_cache.sv
module split_way_cache
    import swc_pkg::*;
#(
    parameter int SETS   = 8,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [1:0]                           cfg_a_ways,
    input  logic                                 req_valid,
    input  logic [TAG_W+$clog2(SETS)-1:0]        req_addr,
    output logic                                 req_ready,
    output logic                                 resp_valid,
    output logic [1:0]                           resp_kind,
    output logic [1:0]                           resp_pos,
    output logic [DATA_W-1:0]                    resp_data,
    output logic                                 fill_req,
    output logic [TAG_W+$clog2(SETS)-1:0]        fill_addr,
    input  logic                                 fill_valid,
    input  logic [DATA_W-1:0]                    fill_data
);
    localparam int IDX_W  = $clog2(SETS);
    localparam int ADDR_W = TAG_W + IDX_W;

    typedef struct packed {
        fsm_e                                   st;
        logic [2:0]                             a_cnt;
        logic [TAG_W-1:0]                       tag;
        logic [IDX_W-1:0]                       idx;
        logic                                   rv;
        kind_e                                  kind;
        logic [POS_W-1:0]                       pos;
        logic [DATA_W-1:0]                      rdata;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]   tags;
        logic [SETS-1:0][WAYS-1:0][DATA_W-1:0]  data;
        logic [SETS-1:0][WAYS-1:0]              valid;
        logic [SETS-1:0][WAYS-1:0][POS_W-1:0]   order;
    } regs_t;

    regs_t r_q, r_d;

    logic                          idle;
    logic [2:0]                    live_a;
    logic [IDX_W-1:0]              cur_idx;
    logic [TAG_W-1:0]              cur_tag;
    logic                          a_hit, b_hit;
    logic [POS_W-1:0]              a_pos, b_pos, a_way, b_way;
    logic [POS_W-1:0]              promo_pos;
    logic [WAYS-1:0][POS_W-1:0]    promo_order;

    assign idle    = (r_q.st == ST_IDLE);
    assign live_a  = idle ? (3'({1'b0, cfg_a_ways}) + 3'd1) : r_q.a_cnt;
    assign cur_idx = idle ? req_addr[IDX_W-1:0] : r_q.idx;
    assign cur_tag = idle ? req_addr[ADDR_W-1:IDX_W] : r_q.tag;

    swc_probe #(.TAG_W(TAG_W)) probe_a_i (
        .way_tag   (r_q.tags[cur_idx]),
        .way_valid (r_q.valid[cur_idx]),
        .order     (r_q.order[cur_idx]),
        .tag       (cur_tag),
        .lo_pos    (3'd0),
        .hi_pos    (live_a - 3'd1),
        .hit       (a_hit),
        .pos       (a_pos),
        .way       (a_way)
    );

    swc_probe #(.TAG_W(TAG_W)) probe_b_i (
        .way_tag   (r_q.tags[cur_idx]),
        .way_valid (r_q.valid[cur_idx]),
        .order     (r_q.order[cur_idx]),
        .tag       (cur_tag),
        .lo_pos    (live_a),
        .hi_pos    (3'(WAYS - 1)),
        .hit       (b_hit),
        .pos       (b_pos),
        .way       (b_way)
    );

    always_comb begin
        case (r_q.st)
            ST_PROBE_B: promo_pos = b_pos;
            ST_FILL:    promo_pos = POS_W'(WAYS - 1);
            default:    promo_pos = a_pos;
        endcase
    end

    swc_promote promote_i (
        .order_in  (r_q.order[cur_idx]),
        .pos       (promo_pos),
        .a_cnt     (live_a),
        .order_out (promo_order)
    );

    always_comb begin
        logic [POS_W-1:0] victim;
        r_d    = r_q;
        r_d.rv = 1'b0;
        victim = r_q.order[r_q.idx][WAYS-1];
        case (r_q.st)
            ST_IDLE: begin
                r_d.a_cnt = live_a;
                if (req_valid) begin
                    r_d.tag = cur_tag;
                    r_d.idx = cur_idx;
                    if (a_hit) begin
                        r_d.rv             = 1'b1;
                        r_d.kind           = KIND_A_HIT;
                        r_d.pos            = a_pos;
                        r_d.rdata          = r_q.data[cur_idx][a_way];
                        r_d.order[cur_idx] = promo_order;
                    end else if (live_a == 3'(WAYS)) begin
                        r_d.st = ST_FILL;
                    end else begin
                        r_d.st = ST_PROBE_B;
                    end
                end
            end
            ST_PROBE_B: begin
                if (b_hit) begin
                    r_d.rv             = 1'b1;
                    r_d.kind           = KIND_B_HIT;
                    r_d.pos            = b_pos;
                    r_d.rdata          = r_q.data[cur_idx][b_way];
                    r_d.order[cur_idx] = promo_order;
                    r_d.st             = ST_IDLE;
                end else begin
                    r_d.st = ST_FILL;
                end
            end
            ST_FILL: begin
                if (fill_valid) begin
                    r_d.tags[r_q.idx][victim]  = r_q.tag;
                    r_d.data[r_q.idx][victim]  = fill_data;
                    r_d.valid[r_q.idx][victim] = 1'b1;
                    r_d.order[r_q.idx]         = promo_order;
                    r_d.rv                     = 1'b1;
                    r_d.kind                   = KIND_MISS;
                    r_d.pos                    = '0;
                    r_d.rdata                  = fill_data;
                    r_d.st                     = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
            for (int s = 0; s < SETS; s++) begin
                for (int p = 0; p < WAYS; p++) begin
                    r_q.order[s][p] <= POS_W'(p);
                end
            end
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = idle;
    assign resp_valid = r_q.rv;
    assign resp_kind  = r_q.kind;
    assign resp_pos   = r_q.pos;
    assign resp_data  = r_q.rdata;
    assign fill_req   = (r_q.st == ST_FILL);
    assign fill_addr  = {r_q.tag, r_q.idx};
endmodule

// File: rtl/swc_checker.sv
module swc_checker #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_a_ways,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic [1:0]        resp_kind,
    input logic [1:0]        resp_pos,
    input logic              fill_req,
    input logic [ADDR_W-1:0] fill_addr,
    input logic              fill_valid
);
    a_r1_no_fill_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !fill_req);

    a_r2_fast_hit_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind == 2'd1) |-> $past(req_valid && req_ready));

    a_r3_slow_hit_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind == 2'd2) |-> $past(!req_ready && !fill_req));

    a_r5_fill_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_valid) |=> (fill_req && $stable(fill_addr)));

    a_r5_miss_after_reply: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind == 2'd3) |-> (resp_pos == 2'd0 && $past(fill_req && fill_valid)));

    a_r6_full_fast_no_probe: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && cfg_a_ways == 2'd3) |=> (resp_valid || fill_req));

    a_r9_resp_at_idle: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (req_ready && resp_kind != 2'd0));
endmodule

bind split_way_cache swc_checker #(.ADDR_W(TAG_W + $clog2(SETS))) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_a_ways (cfg_a_ways),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_kind  (resp_kind),
    .resp_pos   (resp_pos),
    .fill_req   (fill_req),
    .fill_addr  (fill_addr),
    .fill_valid (fill_valid)
);

// File: tb/split_way_cache_tb_top.sv
module split_way_cache_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SETS   = 8;
    localparam int TAG_W  = 8;
    localparam int DATA_W = 16;
    localparam int ADDR_W = TAG_W + $clog2(SETS);

    localparam logic [1:0] K_A = 2'd1, K_B = 2'd2, K_M = 2'd3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cfg_a_ways = 2'd3;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_ready;
    logic              resp_valid;
    logic [1:0]        resp_kind;
    logic [1:0]        resp_pos;
    logic [DATA_W-1:0] resp_data;
    logic              fill_req;
    logic [ADDR_W-1:0] fill_addr;
    logic              fill_valid = 1'b0;
    logic [DATA_W-1:0] fill_data = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    split_way_cache #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_a_ways(cfg_a_ways),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_kind(resp_kind), .resp_pos(resp_pos),
        .resp_data(resp_data), .fill_req(fill_req), .fill_addr(fill_addr),
        .fill_valid(fill_valid), .fill_data(fill_data)
    );

    function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx);
        return {8'(tag), 3'(idx)};
    endfunction

    function automatic logic [DATA_W-1:0] data_of(input logic [ADDR_W-1:0] a);
        return {5'b10110, a} ^ 16'h3C5A;
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] v);
        @(negedge clk);
        cfg_a_ways = v;
    endtask

    // Runs one access; answers a line request with data_of(addr).
    task automatic expect_access(input logic [ADDR_W-1:0] addr, input logic [1:0] ekind,
                                 input logic [1:0] epos, input int elat, input int efill,
                                 input string req);
        int lat;
        int flat;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = addr;
        @(negedge clk);
        req_valid = 1'b0;
        lat  = 1;
        flat = 0;
        while (!resp_valid && lat < 40) begin
            if (fill_req && flat == 0) begin
                flat = lat;
                chk(req, "fill_addr", fill_addr, addr);
                fill_valid = 1'b1;
                fill_data  = data_of(addr);
                @(negedge clk);
                fill_valid = 1'b0;
            end else begin
                @(negedge clk);
            end
            lat++;
        end
        chk(req, "resp_kind", resp_kind, ekind);
        chk(req, "resp_pos", resp_pos, epos);
        chk(req, "resp_data", resp_data, data_of(addr));
        chk(req, "latency", lat, elat);
        chk(req, "fill cycle", flat, efill);
    endtask

    task automatic t_reset();
        chk("R1", "req_ready", req_ready, 1);
        chk("R1", "resp_valid", resp_valid, 0);
        chk("R1", "fill_req", fill_req, 0);
        set_cfg(2'd1);
        expect_access(mk(8'h11, 0), K_M, 2'd0, 3, 2, "R1");
    endtask

    // Set 1 filled with four fast ways: order afterwards t4,t3,t2,t1.
    task automatic t_fill_full_fast();
        set_cfg(2'd3);
        for (int t = 1; t <= 4; t++) expect_access(mk(t, 1), K_M, 2'd0, 2, 1, "R6");
    endtask

    task automatic t_split_behaviour();
        set_cfg(2'd1);                                        // two fast ways
        expect_access(mk(3, 1), K_A, 2'd1, 1, 0, "R10");      // t3,t4,t2,t1
        expect_access(mk(1, 1), K_B, 2'd3, 2, 0, "R3");       // t1,t3,t2,t4
        expect_access(mk(1, 1), K_A, 2'd0, 1, 0, "R2");
        expect_access(mk(4, 1), K_B, 2'd3, 2, 0, "R4");       // t4,t1,t2,t3
        expect_access(mk(2, 1), K_B, 2'd2, 2, 0, "R4");       // t2,t4,t1,t3
        expect_access(mk(5, 1), K_M, 2'd0, 3, 2, "R5");       // t5,t2,t1,t4
        expect_access(mk(4, 1), K_B, 2'd3, 2, 0, "R7");       // t4,t5,t1,t2
        expect_access(mk(3, 1), K_M, 2'd0, 3, 2, "R7");       // t3,t4,t1,t5
    endtask

    task automatic t_resize();
        set_cfg(2'd0);                                        // one fast way
        expect_access(mk(4, 1), K_B, 2'd1, 2, 0, "R10");      // t4,t3,t1,t5
        set_cfg(2'd2);                                        // three fast ways
        expect_access(mk(1, 1), K_A, 2'd2, 1, 0, "R8");       // t1,t4,t3,t5
        expect_access(mk(5, 1), K_B, 2'd3, 2, 0, "R4");       // t5,t1,t4,t3
        set_cfg(2'd3);
        expect_access(mk(3, 1), K_A, 2'd3, 1, 0, "R8");       // t3,t5,t1,t4
        expect_access(mk(1, 1), K_A, 2'd2, 1, 0, "R8");       // t1,t3,t5,t4
        expect_access(mk(5, 1), K_A, 2'd2, 1, 0, "R8");
    endtask

    task automatic t_busy_ignore();
        logic [ADDR_W-1:0] x;
        x = mk(8'h21, 2);
        set_cfg(2'd3);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = x;
        @(negedge clk);
        chk("R6", "fill_req", fill_req, 1);
        req_addr = mk(8'h33, 2);
        for (int i = 0; i < 3; i++) begin
            chk("R9", "req_ready", req_ready, 0);
            chk("R9", "fill_addr", fill_addr, x);
            @(negedge clk);
        end
        req_valid  = 1'b0;
        fill_valid = 1'b1;
        fill_data  = data_of(x);
        @(negedge clk);
        fill_valid = 1'b0;
        chk("R5", "resp_valid", resp_valid, 1);
        chk("R5", "resp_kind", resp_kind, K_M);
        chk("R5", "resp_data", resp_data, data_of(x));
        @(negedge clk);
        chk("R9", "fill_req after", fill_req, 0);
        chk("R9", "resp_valid after", resp_valid, 0);
        chk("R9", "req_ready after", req_ready, 1);
    endtask

    task automatic t_stray_fill();
        @(negedge clk);
        fill_valid = 1'b1;
        fill_data  = 16'hDEAD;
        @(negedge clk);
        chk("R11", "resp_valid", resp_valid, 0);
        chk("R11", "req_ready", req_ready, 1);
        @(negedge clk);
        fill_valid = 1'b0;
        chk("R11", "resp_valid", resp_valid, 0);
        expect_access(mk(8'h21, 2), K_A, 2'd0, 1, 0, "R11");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_full_fast();
        t_split_behaviour();
        t_resize();
        t_busy_ignore();
        t_stray_fill();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule